// File: doc/BRIEF.md
# Video Sync Polarity and Routing Unit

This block prepares the horizontal and vertical sync inputs of a display controller. Each input, and a sync-on-green composite input, passes through a two-flop synchronizer into the system clock domain. The synchronized horizontal and vertical levels can be read back as status. A measurement stage compares the high time of each sync against its low time over every period. The shorter phase is taken as the sync pulse, and from that the stage reports whether the input has positive or negative polarity.

A control register picks the source of the horizontal sync output. The source can be the separate horizontal input or a composite source, and the composite source is either the horizontal pin or the sync-on-green pin. As an alternative, the outputs can come from a free-running generator whose period and pulse-width counts are programmable. The horizontal output can be inverted. An output enable stands in for pin multiplexing. Software reaches all of this through a small register port that is written and read with one address per register.

Register map (16-bit data):
- Address 0 is control. bit0 = generator select, bit1 = composite mode, bit2 = sync-on-green select, bit3 = horizontal output invert, bit4 = output enable.
- Address 1 is status and is read-only. bit0 = horizontal level, bit1 = vertical level, bit2 = horizontal polarity, bit3 = vertical polarity.
- Addresses 2 and 3 hold the horizontal period and pulse width, counted in clocks.
- Addresses 4 and 5 hold the vertical period and pulse width, counted in lines.

Top module: `sync_route_unit`

## Requirements
- R1: Status bit0 reads the synchronized level of the horizontal input and status bit1 reads the synchronized level of the vertical input.
- R2: A polarity bit (status bit2 for horizontal, bit3 for vertical) becomes 1 when the measured high phase is shorter than the low phase. It becomes 0 when the low phase is shorter. An equal comparison leaves the bit unchanged.
- R3: Reset clears both polarity bits to 0.
- R4: With control bit3 at 0 the horizontal output equals the selected horizontal source. With bit3 at 1 it is that source inverted.
- R5: When composite mode (bit1) is set, bit2 = 1 selects the sync-on-green input and bit2 = 0 selects the horizontal input. When composite mode is clear, the sync-on-green input has no effect.
- R6: In composite mode with the generator not selected, the vertical output is held low.
- R7: With control bit0 set, both outputs come from the free-running generator. The horizontal pulse is high for H_WIDTH of every H_PERIOD clocks. The vertical pulse is high for V_WIDTH of every V_PERIOD lines.
- R8: Reset clears every control bit to 0, and the control register reads back the value last written to it.
- R9: While the output enable (bit4) is 0, both outputs are driven low.
- R10: In pass-through mode, a change on an input pin appears on the corresponding output on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for bus_addr |
| hsync_in | input | 1 | Horizontal or composite sync pin |
| vsync_in | input | 1 | Vertical sync pin |
| sog_in | input | 1 | Sync-on-green composite pin |
| hsync_out | output | 1 | Conditioned horizontal sync output |
| vsync_out | output | 1 | Conditioned vertical sync output |

## Verification
Some properties are checked by assertions on every cycle:
- the output enable forces both outputs low;
- in pass-through mode the horizontal output follows the synchronized input, combined with the invert bit;
- composite mode keeps the vertical output low;
- the polarity bits are zero after reset;
- the synchronizer delay and the generator counter wrap.

Other properties only the bench scenarios can show:
- that the polarity measurement reaches the correct verdict for short-high and short-low waveforms;
- that the generator produces the programmed duty over whole frames;
- that the sync-on-green pin is selected only in composite mode.

// File: rtl/sync_route_pkg.sv
package sync_route_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_HPER   = 3'd2;
  localparam logic [ADDR_W-1:0] A_HWID   = 3'd3;
  localparam logic [ADDR_W-1:0] A_VPER   = 3'd4;
  localparam logic [ADDR_W-1:0] A_VWID   = 3'd5;

  typedef struct packed {
    logic out_en;   // bit4
    logic h_inv;    // bit3
    logic sog_sel;  // bit2
    logic comp;     // bit1
    logic gen_sel;  // bit0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  p_sync_delay_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/sync_polarity_meter.sv
module sync_polarity_meter #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pol
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lvl_q;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] high_len;
  logic             seen_rise;
  logic             high_valid;
  logic             rise, fall;

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q      <= 1'b0;
      run_cnt    <= '0;
      high_len   <= '0;
      seen_rise  <= 1'b0;
      high_valid <= 1'b0;
      pol        <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (rise || fall) run_cnt <= '0;
      else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;

      if (fall) begin
        high_len   <= run_cnt;
        high_valid <= seen_rise;
      end
      if (rise) begin
        seen_rise <= 1'b1;
        if (high_valid) begin
          if (high_len < run_cnt)      pol <= 1'b1;
          else if (high_len > run_cnt) pol <= 1'b0;
        end
      end
    end
  end

  p_pol_clear_r3: assert property (@(posedge clk) rst |=> (pol == 1'b0));
  p_pol_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rise) |-> $stable(pol));
endmodule

// File: rtl/sync_freerun_gen.sv
module sync_freerun_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] h_period,
  input  logic [CNT_W-1:0] h_width,
  input  logic [CNT_W-1:0] v_period,
  input  logic [CNT_W-1:0] v_width,
  output logic             gen_h,
  output logic             gen_v
);
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic             h_wrap, v_wrap;

  assign h_wrap = (h_period == '0) || (h_cnt >= h_period - 1'b1);
  assign v_wrap = (v_period == '0) || (v_cnt >= v_period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt <= '0;
      v_cnt <= '0;
      gen_h <= 1'b0;
      gen_v <= 1'b0;
    end else begin
      if (h_wrap) begin
        h_cnt <= '0;
        v_cnt <= v_wrap ? '0 : v_cnt + 1'b1;
      end else begin
        h_cnt <= h_cnt + 1'b1;
      end
      gen_h <= (h_cnt < h_width);
      gen_v <= (v_cnt < v_width);
    end
  end

  p_hcnt_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    ((h_period != '0) && (h_cnt >= h_period)) |=> (h_cnt == '0));
  p_vcnt_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (v_period == '0) |=> (v_cnt == '0));
endmodule

// File: rtl/sync_route_regs.sv
module sync_route_regs
  import sync_route_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [3:0]        status,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  h_period,
  output logic [CNT_W-1:0]  h_width,
  output logic [CNT_W-1:0]  v_period,
  output logic [CNT_W-1:0]  v_width
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      h_period <= '0;
      h_width  <= '0;
      v_period <= '0;
      v_width  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: ctrl     <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        A_HPER: h_period <= bus_wdata[CNT_W-1:0];
        A_HWID: h_width  <= bus_wdata[CNT_W-1:0];
        A_VPER: v_period <= bus_wdata[CNT_W-1:0];
        A_VWID: v_width  <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:   rd_mux[CTRL_W-1:0] = ctrl;
      A_STATUS: rd_mux[3:0]        = status;
      A_HPER:   rd_mux[CNT_W-1:0]  = h_period;
      A_HWID:   rd_mux[CNT_W-1:0]  = h_width;
      A_VPER:   rd_mux[CNT_W-1:0]  = v_period;
      A_VWID:   rd_mux[CNT_W-1:0]  = v_width;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  p_ctrl_write_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CTRL) |=> (ctrl == $past(bus_wdata[CTRL_W-1:0])));
  p_ctrl_reset_r8: assert property (@(posedge clk) rst |=> (ctrl == '0));
endmodule

// File: rtl/sync_route_unit.sv
module sync_route_unit
  import sync_route_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              sog_in,
  output logic              hsync_out,
  output logic              vsync_out
);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] pins_s;
  logic              hs_s, vs_s, sog_s;
  logic              h_pol, v_pol;
  logic              gen_h, gen_v;
  ctrl_t             ctrl;
  logic [CNT_W-1:0]  h_period, h_width, v_period, v_width;
  logic              h_src, v_src;

  sync_2ff #(.WIDTH(NUM_IN)) u_sync (
    .clk(clk), .rst(rst),
    .d({sog_in, vsync_in, hsync_in}),
    .q(pins_s)
  );
  assign hs_s  = pins_s[0];
  assign vs_s  = pins_s[1];
  assign sog_s = pins_s[2];

  sync_polarity_meter #(.CNT_W(CNT_W)) u_hpol (
    .clk(clk), .rst(rst), .lvl(hs_s), .pol(h_pol));
  sync_polarity_meter #(.CNT_W(CNT_W)) u_vpol (
    .clk(clk), .rst(rst), .lvl(vs_s), .pol(v_pol));

  sync_freerun_gen #(.CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst(rst),
    .h_period(h_period), .h_width(h_width),
    .v_period(v_period), .v_width(v_width),
    .gen_h(gen_h), .gen_v(gen_v));

  sync_route_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status({v_pol, h_pol, vs_s, hs_s}),
    .ctrl(ctrl),
    .h_period(h_period), .h_width(h_width),
    .v_period(v_period), .v_width(v_width));

  always_comb begin
    if (ctrl.gen_sel) begin
      h_src = gen_h;
      v_src = gen_v;
    end else if (ctrl.comp) begin
      h_src = ctrl.sog_sel ? sog_s : hs_s;
      v_src = 1'b0;
    end else begin
      h_src = hs_s;
      v_src = vs_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_out <= 1'b0;
      vsync_out <= 1'b0;
    end else begin
      hsync_out <= ctrl.out_en & (h_src ^ ctrl.h_inv);
      vsync_out <= ctrl.out_en & v_src;
    end
  end

  p_out_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !ctrl.out_en |=> (!hsync_out && !vsync_out));
  p_pass_inv_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.out_en && !ctrl.gen_sel && !ctrl.comp) |=>
      (hsync_out == ($past(hs_s) ^ $past(ctrl.h_inv))));
  p_comp_vlow_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.comp && !ctrl.gen_sel) |=> !vsync_out);
endmodule

// File: tb/test_sync_route_unit.sv
module test_sync_route_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        hsync_in, vsync_in, sog_in;
  logic        hsync_out, vsync_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_route_unit i_sync_route_unit (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .sog_in(sog_in),
    .hsync_out(hsync_out), .vsync_out(vsync_out));

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    wait_cyc(2);
    d = bus_rdata;
  endtask

  task automatic drive_h(int hi, int lo, int periods);
    for (int p = 0; p < periods; p++) begin
      hsync_in = 1'b1; wait_cyc(hi);
      hsync_in = 1'b0; wait_cyc(lo);
    end
  endtask

  task automatic drive_v(int hi, int lo, int periods);
    for (int p = 0; p < periods; p++) begin
      vsync_in = 1'b1; wait_cyc(hi);
      vsync_in = 1'b0; wait_cyc(lo);
    end
  endtask

  task automatic t_reset_state();
    logic [15:0] d;
    check("R9 hsync_out after reset", hsync_out, 0);
    check("R9 vsync_out after reset", vsync_out, 0);
    rd(3'd0, d);
    check("R8 ctrl after reset", d, 0);
    rd(3'd1, d);
    check("R3 polarity bits after reset", d[3:2], 0);
  endtask

  task automatic t_levels();
    logic [15:0] d;
    hsync_in = 1'b1; vsync_in = 1'b0; wait_cyc(4);
    rd(3'd1, d);
    check("R1 hs level high", d[0], 1);
    check("R1 vs level low", d[1], 0);
    hsync_in = 1'b0; vsync_in = 1'b1; wait_cyc(4);
    rd(3'd1, d);
    check("R1 hs level low", d[0], 0);
    check("R1 vs level high", d[1], 1);
    vsync_in = 1'b0; wait_cyc(4);
  endtask

  task automatic t_latency();
    logic [15:0] d;
    wr(3'd0, 16'h0010);
    rd(3'd0, d);
    check("R8 ctrl readback", d, 16'h0010);
    hsync_in = 1'b0; wait_cyc(4);
    @(negedge clk);
    hsync_in = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R10 no change after two edges", hsync_out, 0);
    @(posedge clk); #1;
    check("R10 change on third edge", hsync_out, 1);
    wait_cyc(2);
  endtask

  task automatic t_invert();
    wr(3'd0, 16'h0018);
    hsync_in = 1'b1; wait_cyc(4);
    check("R4 inverted high input", hsync_out, 0);
    hsync_in = 1'b0; wait_cyc(4);
    check("R4 inverted low input", hsync_out, 1);
    wr(3'd0, 16'h0010);
    wait_cyc(4);
    check("R4 non-inverted low input", hsync_out, 0);
  endtask

  task automatic t_polarity();
    logic [15:0] d;
    drive_h(3, 12, 4);
    wait_cyc(4);
    rd(3'd1, d);
    check("R2 h short-high positive", d[2], 1);
    drive_h(12, 3, 4);
    hsync_in = 1'b1; wait_cyc(4);
    rd(3'd1, d);
    check("R2 h short-low negative", d[2], 0);
    hsync_in = 1'b0; wait_cyc(4);
    drive_v(2, 20, 4);
    wait_cyc(4);
    rd(3'd1, d);
    check("R2 v short-high positive", d[3], 1);
    drive_h(3, 12, 4);
    wait_cyc(4);
    do_reset();
    rd(3'd1, d);
    check("R3 polarity cleared by reset", d[3:2], 0);
  endtask

  task automatic t_composite();
    wr(3'd0, 16'h0016);
    hsync_in = 1'b0; sog_in = 1'b1; vsync_in = 1'b1; wait_cyc(4);
    check("R5 sog selected in composite", hsync_out, 1);
    check("R6 vsync low in composite", vsync_out, 0);
    wr(3'd0, 16'h0012);
    wait_cyc(4);
    check("R5 hsync pin selected in composite", hsync_out, 0);
    wr(3'd0, 16'h0014);
    wait_cyc(4);
    check("R5 sog ignored without composite", hsync_out, 0);
    check("R6 vsync passes without composite", vsync_out, 1);
    sog_in = 1'b0; vsync_in = 1'b0; wait_cyc(4);
  endtask

  task automatic t_generator();
    int hc, vc;
    wr(3'd2, 16'd10);
    wr(3'd3, 16'd3);
    wr(3'd4, 16'd4);
    wr(3'd5, 16'd1);
    wr(3'd0, 16'h0011);
    wait_cyc(100);
    hc = 0; vc = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      hc += int'(hsync_out);
      vc += int'(vsync_out);
    end
    check("R7 generated h high cycles", hc, 120);
    check("R7 generated v high cycles", vc, 100);
    wr(3'd0, 16'h0001);
    wait_cyc(2);
    hc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hc += int'(hsync_out) + int'(vsync_out);
    end
    check("R9 outputs low when disabled", hc, 0);
  endtask

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    hsync_in = 1'b0; vsync_in = 1'b0; sog_in = 1'b0;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
    t_reset_state();
    t_levels();
    t_latency();
    t_invert();
    t_polarity();
    t_composite();
    t_generator();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule